// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Register File

This block is the register front end of a descriptor-driven DMA dispatcher. It sits on a 32-bit memory-mapped slave port with five word registers: a status register, a control register, and three read-only views of the FIFO fill levels and sequence numbers. The FIFOs and the data movers sit outside the block. It takes their live flags and counts in, and it takes a one-cycle completion pulse for each finished descriptor. That pulse carries the descriptor's interrupt request, error bits, error-interrupt mask and early-termination flag.

The status register mixes two kinds of bits. Some are live flags taken straight from the FIFOs and the engine. Others are sticky flags that software clears by writing a one to them. A software reset is requested through the control register. It runs for a fixed number of cycles, during which the FIFOs are told to flush, and it is visible as a resetting bit that software polls. A stop request, or a sticky stop on error or on early termination, halts descriptor dispatch. A single level interrupt is driven from the sticky interrupt bit, gated by a global enable.

Top module: `dma_csr_regs`

## Requirements
- R1: Control register at byte offset 0x04. Bits 0 (stop), 2 (stop on error), 3 (stop on early termination), 4 (global interrupt enable) and 5 (halt descriptor fetch) are read/write. Bit 1 reads 1 while a reset is in progress. Bits 31:6 read 0.
- R2: Status register at offset 0x00. Bits 0 to 4 are the live inputs engine busy, descriptor FIFO empty, descriptor FIFO full, response FIFO empty and response FIFO full. Bits 31:10 read 0.
- R3: Offset 0x08 reads {write fill, read fill} (write fill in bits 31:16). Offset 0x0C reads the response fill level in bits 15:0. Offset 0x10 reads {write sequence, read sequence}. Offsets 0x14 to 0x1C read 0.
- R4: Writing 1 to control bit 1 when no reset is running starts a reset lasting RST_CYCLES cycles. During it, status bit 6, control bit 1 and `fifo_flush` are 1. The reset clears the control register and status bits 7 to 9 when it starts, and it ignores bus writes and completion pulses while it runs.
- R5: A completion pulse with nonzero error bits sets status bit 7 (stopped on error) if control bit 2 is set. A completion pulse with the early flag sets status bit 8 (stopped on early termination) if control bit 3 is set.
- R6: Status bit 5 (stopped) is control bit 0 OR status bit 7 OR status bit 8. `dispatch_halt` is stopped OR control bit 5 OR reset in progress.
- R7: Status bit 9 (interrupt pending) sets on a completion pulse whose interrupt request is set, or whose error bits ANDed with its error mask are nonzero.
- R8: The `irq` output is status bit 9 AND control bit 4.
- R9: Writing 1 to status bits 7, 8 or 9 clears that bit. Writing to the other status bits has no effect. A set and a clear of the same bit in the same cycle leave it set.
- R10: Writes to offsets 0x08, 0x0C and 0x10 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| eng_busy | input | 1 | Data engine busy |
| desc_empty | input | 1 | Descriptor FIFO empty |
| desc_full | input | 1 | Descriptor FIFO full |
| resp_empty | input | 1 | Response FIFO empty |
| resp_full | input | 1 | Response FIFO full |
| rd_fill | input | 16 | Read-side descriptor fill level |
| wr_fill | input | 16 | Write-side descriptor fill level |
| resp_fill | input | 16 | Response FIFO fill level |
| rd_seq | input | 16 | Read sequence number |
| wr_seq | input | 16 | Write sequence number |
| done_pulse | input | 1 | One-cycle descriptor completion |
| done_irq_req | input | 1 | Completed descriptor asks for an interrupt |
| done_err | input | 8 | Error bits of the completion |
| done_err_mask | input | 8 | Error-interrupt enable bits of the completion |
| done_early | input | 1 | Completion ended early |
| fifo_flush | output | 1 | FIFOs flush while reset runs |
| dispatch_halt | output | 1 | Descriptor dispatch must stop |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with RST_CYCLES set to 5 instead of 16. This lets reset requests issued back to back, and writes or completion pulses landing in the last reset cycle and in the first cycle after it, occur many times within a short random run. The address width stays at its default of 5, so every unmapped word from 0x14 to 0x1C is read as well.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [2:0] {
        RG_STATUS = 3'd0,
        RG_CTRL   = 3'd1,
        RG_FILL   = 3'd2,
        RG_RESP   = 3'd3,
        RG_SEQ    = 3'd4
    } reg_idx_e;

    localparam int unsigned CB_STOP      = 0;
    localparam int unsigned CB_RESET     = 1;
    localparam int unsigned CB_STOP_ERR  = 2;
    localparam int unsigned CB_STOP_EARL = 3;
    localparam int unsigned CB_GIE       = 4;
    localparam int unsigned CB_HALT_DESC = 5;

    localparam int unsigned SB_ERR   = 7;
    localparam int unsigned SB_EARLY = 8;
    localparam int unsigned SB_IRQ   = 9;

    typedef struct packed {
        logic halt_desc;
        logic gie;
        logic stop_early;
        logic stop_err;
        logic stop;
    } ctrl_t;

    typedef struct packed {
        logic irq;
        logic early;
        logic err;
    } sticky_t;
endpackage

// File: rtl/dcsr_rst_seq.sv
module dcsr_rst_seq #(
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int unsigned CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.act) begin
            if (s_q.cnt == '0) s_d.act = 1'b0;
            else               s_d.cnt = s_q.cnt - 1'b1;
        end else if (start) begin
            s_d.act = 1'b1;
            s_d.cnt = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.act;

    // R4: a reset only begins after a request
    p_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.act) |-> $past(start));
    // R4: the down-counter never exceeds its load value
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.act |-> (s_q.cnt <= LOAD));
    // R4: the sequence ends after the final count
    p_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act && s_q.cnt == '0) |=> !s_q.act);
endmodule

// File: rtl/dcsr_sticky.sv
module dcsr_sticky
    import dcsr_pkg::*;
#(
    parameter int unsigned ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             clr_all,
    input  sticky_t          w1c,
    input  logic             ev_done,
    input  logic             ev_irq_req,
    input  logic [ERR_W-1:0] ev_err,
    input  logic [ERR_W-1:0] ev_err_mask,
    input  logic             ev_early,
    input  logic             stop_on_err,
    input  logic             stop_on_early,
    output sticky_t          flags
);
    sticky_t f_d, f_q;
    logic    err_hit, irq_hit;

    always_comb begin
        err_hit = ev_done && (|ev_err) && stop_on_err;
        irq_hit = ev_done && (ev_irq_req || (|(ev_err & ev_err_mask)));
        f_d = f_q;
        if (clr_all) begin
            f_d = '0;
        end else if (!hold) begin
            f_d = f_q & ~w1c;
            if (err_hit)                          f_d.err   = 1'b1;
            if (ev_done && ev_early && stop_on_early) f_d.early = 1'b1;
            if (irq_hit)                          f_d.irq   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q;

    // R5: stopped-on-error only sets from a qualifying error
    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.err) |-> $past(ev_done && stop_on_err && !hold));
    // R7: pending interrupt only sets from a completion pulse
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.irq) |-> $past(ev_done && !hold));
    // R4: sticky bits frozen while held
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr_all) |=> $stable(f_q));
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
    import dcsr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned LVL_W      = 16,
    parameter int unsigned ERR_W      = 8,
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              eng_busy,
    input  logic              desc_empty,
    input  logic              desc_full,
    input  logic              resp_empty,
    input  logic              resp_full,
    input  logic [LVL_W-1:0]  rd_fill,
    input  logic [LVL_W-1:0]  wr_fill,
    input  logic [LVL_W-1:0]  resp_fill,
    input  logic [LVL_W-1:0]  rd_seq,
    input  logic [LVL_W-1:0]  wr_seq,
    input  logic              done_pulse,
    input  logic              done_irq_req,
    input  logic [ERR_W-1:0]  done_err,
    input  logic [ERR_W-1:0]  done_err_mask,
    input  logic              done_early,
    output logic              fifo_flush,
    output logic              dispatch_halt,
    output logic              irq
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             wr_status, wr_ctrl, rst_start, rst_active, stopped;
    ctrl_t            ctrl_d, ctrl_q;
    sticky_t          w1c, flags;

    assign idx       = addr[ADDR_W-1:2];
    assign wr_status = wr_en && (idx == IDX_W'(RG_STATUS));
    assign wr_ctrl   = wr_en && (idx == IDX_W'(RG_CTRL));
    assign rst_start = wr_ctrl && wr_data[CB_RESET] && !rst_active;

    always_comb begin
        ctrl_d = ctrl_q;
        w1c    = '0;
        if (rst_start) begin
            ctrl_d = '0;
        end else if (!rst_active) begin
            if (wr_ctrl) begin
                ctrl_d.stop       = wr_data[CB_STOP];
                ctrl_d.stop_err   = wr_data[CB_STOP_ERR];
                ctrl_d.stop_early = wr_data[CB_STOP_EARL];
                ctrl_d.gie        = wr_data[CB_GIE];
                ctrl_d.halt_desc  = wr_data[CB_HALT_DESC];
            end
            if (wr_status) begin
                w1c.err   = wr_data[SB_ERR];
                w1c.early = wr_data[SB_EARLY];
                w1c.irq   = wr_data[SB_IRQ];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    dcsr_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rst_start),
        .active (rst_active)
    );

    dcsr_sticky #(.ERR_W(ERR_W)) u_sticky (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold          (rst_active),
        .clr_all       (rst_start),
        .w1c           (w1c),
        .ev_done       (done_pulse),
        .ev_irq_req    (done_irq_req),
        .ev_err        (done_err),
        .ev_err_mask   (done_err_mask),
        .ev_early      (done_early),
        .stop_on_err   (ctrl_q.stop_err),
        .stop_on_early (ctrl_q.stop_early),
        .flags         (flags)
    );

    assign stopped       = ctrl_q.stop || flags.err || flags.early;
    assign dispatch_halt = stopped || ctrl_q.halt_desc || rst_active;
    assign fifo_flush    = rst_active;
    assign irq           = flags.irq && ctrl_q.gie;

    always_comb begin
        rd_data = '0;
        case (idx)
            IDX_W'(RG_STATUS): rd_data = {22'd0, flags.irq, flags.early, flags.err,
                                          rst_active, stopped, resp_full, resp_empty,
                                          desc_full, desc_empty, eng_busy};
            IDX_W'(RG_CTRL):   rd_data = {26'd0, ctrl_q.halt_desc, ctrl_q.gie,
                                          ctrl_q.stop_early, ctrl_q.stop_err,
                                          rst_active, ctrl_q.stop};
            IDX_W'(RG_FILL):   rd_data = {wr_fill, rd_fill};
            IDX_W'(RG_RESP):   rd_data = {{(32-LVL_W){1'b0}}, resp_fill};
            IDX_W'(RG_SEQ):    rd_data = {wr_seq, rd_seq};
            default:           rd_data = '0;
        endcase
    end

    // R6: dispatch is halted for the whole reset
    p_halt_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |-> dispatch_halt);
    // R4: control register frozen while a reset runs
    p_ctrl_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> $stable(ctrl_q));
    // R9: clearing the pending bit with no new event drops the interrupt
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && wr_data[SB_IRQ] && !done_pulse && !rst_active) |=> !irq);
    // R8: the interrupt needs the global enable
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q.gie);
endmodule

// File: tb/sim_dma_csr_regs.sv
module sim_dma_csr_regs;
    localparam int RST = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        eng_busy = 0, desc_empty = 0, desc_full = 0, resp_empty = 0, resp_full = 0;
    logic [15:0] rd_fill = 0, wr_fill = 0, resp_fill = 0, rd_seq = 0, wr_seq = 0;
    logic        done_pulse = 0, done_irq_req = 0, done_early = 0;
    logic [7:0]  done_err = 0, done_err_mask = 0;
    logic        fifo_flush, dispatch_halt, irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit [5:0] m_ctrl;
    bit       m_err, m_early, m_irq;
    int       m_left;

    always #5 clk = ~clk;

    dma_csr_regs #(.RST_CYCLES(RST)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .eng_busy(eng_busy), .desc_empty(desc_empty),
        .desc_full(desc_full), .resp_empty(resp_empty), .resp_full(resp_full),
        .rd_fill(rd_fill), .wr_fill(wr_fill), .resp_fill(resp_fill),
        .rd_seq(rd_seq), .wr_seq(wr_seq), .done_pulse(done_pulse),
        .done_irq_req(done_irq_req), .done_err(done_err),
        .done_err_mask(done_err_mask), .done_early(done_early),
        .fifo_flush(fifo_flush), .dispatch_halt(dispatch_halt), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 0; m_err = 0; m_early = 0; m_irq = 0; m_left = 0;
        end else if (m_left > 0) begin
            m_left = m_left - 1;                      // R4: everything ignored
        end else begin
            bit [5:0] oc;
            oc = m_ctrl;
            if (wr_en && addr[4:2] == 3'd1 && wr_data[1]) begin
                m_ctrl = 0; m_err = 0; m_early = 0; m_irq = 0; m_left = RST;
            end else begin
                if (wr_en && addr[4:2] == 3'd1) m_ctrl = {wr_data[5:2], 1'b0, wr_data[0]};
                if (wr_en && addr[4:2] == 3'd0) begin  // R9 write-one-to-clear
                    if (wr_data[7]) m_err = 0;
                    if (wr_data[8]) m_early = 0;
                    if (wr_data[9]) m_irq = 0;
                end
                if (done_pulse) begin
                    if (done_err != 0 && oc[2]) m_err = 1;             // R5
                    if (done_early && oc[3]) m_early = 1;              // R5
                    if (done_irq_req || (done_err & done_err_mask) != 0) m_irq = 1; // R7
                end
            end
        end
    end

    function automatic bit [31:0] model_read();
        bit act, stp;
        act = (m_left > 0);
        stp = m_ctrl[0] | m_err | m_early;
        case (addr[4:2])
            3'd0: return {22'd0, m_irq, m_early, m_err, act, stp,
                          resp_full, resp_empty, desc_full, desc_empty, eng_busy};
            3'd1: return {26'd0, m_ctrl[5:2], act, m_ctrl[0]};
            3'd2: return {wr_fill, rd_fill};
            3'd3: return {16'd0, resp_fill};
            3'd4: return {wr_seq, rd_seq};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string req, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit act, stp;
        act = (m_left > 0);
        stp = m_ctrl[0] | m_err | m_early;
        case (addr[4:2])
            3'd0:    chk("R2 R5 R6 R7 R9 status", rd_data, model_read());
            3'd1:    chk("R1 R4 control", rd_data, model_read());
            default: chk("R3 R10 levels", rd_data, model_read());
        endcase
        chk("R4 fifo_flush", 32'(fifo_flush), 32'(act));
        chk("R6 dispatch_halt", 32'(dispatch_halt), 32'(stp | m_ctrl[5] | act));
        chk("R8 irq", 32'(irq), 32'(m_irq & m_ctrl[4]));
    end

    task automatic tick();
        @(posedge clk);
        #2;
        wr_en = 0; done_pulse = 0; done_irq_req = 0; done_err = 0;
        done_err_mask = 0; done_early = 0;
    endtask

    task automatic wr(bit [4:0] a, bit [31:0] d);
        addr = a; wr_en = 1; wr_data = d;
        tick();
    endtask

    task automatic done(bit irqr, bit [7:0] e, bit [7:0] m, bit early);
        done_pulse = 1; done_irq_req = irqr; done_err = e;
        done_err_mask = m; done_early = early;
        tick();
    endtask

    task automatic look(bit [4:0] a);
        addr = a;
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        look(5'h00); look(5'h04);                       // reset state
        // R2 live flags under several patterns
        eng_busy = 1; desc_full = 1; look(5'h00);
        eng_busy = 0; desc_empty = 1; resp_full = 1; look(5'h00);
        resp_empty = 1; desc_full = 0; look(5'h00);
        // R3 level and sequence views, unmapped words
        rd_fill = 16'h1234; wr_fill = 16'hABCD; resp_fill = 16'h0042;
        rd_seq = 16'h0007; wr_seq = 16'hFFFE;
        for (int a = 0; a < 8; a++) look(5'(a * 4));
        // R10 writes to read-only views
        wr(5'h08, 32'hFFFF_FFFF); wr(5'h0C, 32'hFFFF_FFFF); wr(5'h10, 32'h3FF);
        look(5'h00); look(5'h04);
        // R1 control read/write
        wr(5'h04, 32'hFFFF_FFFD); look(5'h04);
        wr(5'h04, 32'h0); look(5'h04);
        // R5 R6 R7 stops and interrupt
        wr(5'h04, 32'h1C); addr = 5'h00;
        done(0, 8'h01, 8'h00, 0); look(5'h00);
        done(1, 8'h00, 8'h00, 0); look(5'h00);
        done(0, 8'h00, 8'h00, 1); look(5'h00);
        // R9 selective clear, then set-wins
        wr(5'h00, 32'h0000_0080); look(5'h00);
        wr(5'h00, 32'h0000_007F); look(5'h00);
        addr = 5'h00; wr_en = 1; wr_data = 32'h200;
        done(1, 8'h00, 8'h00, 0); look(5'h00);
        // R8 enable off hides the pending bit
        wr(5'h04, 32'h0C); look(5'h00);
        wr(5'h00, 32'h3FF); look(5'h00);
        // R7 masked error without stop-on-error
        wr(5'h04, 32'h10);
        done(0, 8'h30, 8'h01, 0); look(5'h00);
        done(0, 8'h30, 8'h10, 0); look(5'h00);
        // R6 halt-descriptor bit
        wr(5'h04, 32'h20); look(5'h00);
        // R4 reset with activity during it
        wr(5'h04, 32'h1D); done(1, 8'h1, 8'h1, 1);
        wr(5'h04, 32'h02);
        wr(5'h04, 32'h11); wr(5'h00, 32'h3FF);
        done(1, 8'h0, 8'h0, 0);
        for (int i = 0; i < RST + 2; i++) look(5'h00);
        look(5'h04);
        // random traffic for corner overlaps
        for (int i = 0; i < 1500; i++) begin
            addr = 5'($urandom_range(0, 7) * 4);
            wr_en = ($urandom_range(0, 3) == 0);
            wr_data = $urandom;
            if (addr == 5'h04 && $urandom_range(0, 3) != 0) wr_data[1] = 0;
            done_pulse = ($urandom_range(0, 2) == 0);
            done_irq_req = $urandom; done_err = ($urandom_range(0, 1) == 0) ? 8'h0 : 8'($urandom);
            done_err_mask = 8'($urandom); done_early = $urandom;
            {eng_busy, desc_empty, desc_full, resp_empty, resp_full} = 5'($urandom);
            rd_fill = 16'($urandom); wr_seq = 16'($urandom);
            tick();
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule